// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This unit resolves control-flow instructions for a small processor core. For each instruction it is handed, it decides whether the instruction is taken. It then produces the address of the next instruction to fetch and the number of clock cycles the instruction consumes.

Two families of instruction are handled. Conditional relative branches test either a single selected status flag or a derived signed or unsigned comparison. A taken branch jumps by a signed 7-bit offset. Skips test register equality or a single register or I/O bit. A skip that holds steps over the following instruction, which is one or two words long.

Instruction fetch, the call and return stack, and interrupts are handled elsewhere. The unit never changes the status flags. One request is accepted per clock on `evalValid`. The result is registered and presented on the next cycle with `resValid`.

Top module: `branch_skip_eval`

## Requirements
- R1: While `rstN` is low, `resValid`, `resTaken`, `resNextPc` and `resCycles` are all zero.
- R2: `resValid` is high in exactly the cycle after a cycle with `evalValid` high. After a cycle with `evalValid` low, `resValid` is low and `resTaken`, `resNextPc` and `resCycles` keep their previous values.
- R3: Kind 0 (flag set) is taken when `statusFlags[flagSel]` is 1. Kind 1 (flag clear) is taken when that bit is 0.
- R4: Kind 2 (signed greater-or-equal) is taken when N xor V is 0. Kind 3 (signed less-than) is taken when N xor V is 1. N is `statusFlags` bit 2 and V is bit 3.
- R5: Kind 4 (same-or-higher) is taken when C is 0. Kind 5 (lower) is taken when C is 1. C is `statusFlags` bit 0.
- R6: A taken branch (kinds 0 to 5) gives `resNextPc` = `curPc` + sign-extended `relOffset` + 1, modulo 2^PC_W, with `resCycles` = 2.
- R7: A branch or skip whose condition fails gives `resTaken` = 0, `resNextPc` = `curPc` + 1 (modulo 2^PC_W) and `resCycles` = 1.
- R8: Kind 6 skips when `regsEqual` is 1. Kind 7 skips when `bitValue` is 0. Kind 8 skips when `bitValue` is 1.
- R9: A taken skip advances the PC by 3 with `resCycles` = 3 when `nextIsLong` is 1. Otherwise it advances the PC by 2 with `resCycles` = 2.
- R10: `nextIsLong` has no effect on the result of any branch kind (0 to 5).
- R11: Kind codes 9 to 15 are never taken and give `curPc` + 1 with `resCycles` = 1, whatever the flags and bit inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Request strobe; inputs are sampled this cycle |
| curPc | input | PC_W | Address of the branch or skip instruction |
| statusFlags | input | FLAG_W | Status flag byte (C bit 0, N bit 2, V bit 3) |
| flagSel | input | SEL_W | Flag index for kinds 0 and 1 |
| relOffset | input | OFF_W | Signed relative branch offset |
| ctlKind | input | 4 | Instruction kind code (0 to 8 used) |
| bitValue | input | 1 | Tested register or I/O bit for kinds 7 and 8 |
| regsEqual | input | 1 | Register equality result for kind 6 |
| nextIsLong | input | 1 | Following instruction is two words long |
| resValid | output | 1 | Result valid this cycle |
| resTaken | output | 1 | Branch taken or skip performed |
| resNextPc | output | PC_W | Address of the next instruction |
| resCycles | output | 2 | Cycles consumed (1, 2 or 3) |

## Verification
The embedded properties check on every cycle that a result follows each request one cycle later and that idle cycles hold the outputs. They also check that every not-taken result costs one cycle and steps the PC by one, that taken branches cost two cycles and land on the offset target, and that taken skips cost two or three cycles according to the length flag. Which kinds are taken under which flag, bit and equality patterns can only be shown by the bench's scenarios. The same applies to PC wrap at both ends of the address space, the length flag having no effect on branches, and the reserved kind codes. The bench compares all of these against its own model on every request.

// File: rtl/bse_pkg.sv
package bse_pkg;

  typedef enum logic [3:0] {
    KIND_FLAG_SET  = 4'd0,
    KIND_FLAG_CLR  = 4'd1,
    KIND_SGE       = 4'd2,
    KIND_SLT       = 4'd3,
    KIND_CARRY_CLR = 4'd4,
    KIND_CARRY_SET = 4'd5,
    KIND_SKIP_EQ   = 4'd6,
    KIND_SKIP_BCLR = 4'd7,
    KIND_SKIP_BSET = 4'd8
  } flowKind_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  typedef struct packed {
    logic isBranch;
    logic isSkip;
    logic condMet;
  } evalStrobe_t;

endpackage

// File: rtl/bse_ctrl.sv
module bse_ctrl
  import bse_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int SEL_W  = $clog2(FLAG_W)
) (
  input  logic [FLAG_W-1:0] statusFlags,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic [3:0]        ctlKind,
  input  logic              bitValue,
  input  logic              regsEqual,
  output evalStrobe_t       strobe
);

  logic selFlag;
  logic signedLess;
  logic carryBit;

  assign selFlag    = statusFlags[flagSel];
  assign signedLess = statusFlags[FLAG_N] ^ statusFlags[FLAG_V];
  assign carryBit   = statusFlags[FLAG_C];

  always_comb begin
    strobe = '0;
    case (ctlKind)
      KIND_FLAG_SET:  begin strobe.isBranch = 1'b1; strobe.condMet = selFlag;     end
      KIND_FLAG_CLR:  begin strobe.isBranch = 1'b1; strobe.condMet = !selFlag;    end
      KIND_SGE:       begin strobe.isBranch = 1'b1; strobe.condMet = !signedLess; end
      KIND_SLT:       begin strobe.isBranch = 1'b1; strobe.condMet = signedLess;  end
      KIND_CARRY_CLR: begin strobe.isBranch = 1'b1; strobe.condMet = !carryBit;   end
      KIND_CARRY_SET: begin strobe.isBranch = 1'b1; strobe.condMet = carryBit;    end
      KIND_SKIP_EQ:   begin strobe.isSkip   = 1'b1; strobe.condMet = regsEqual;   end
      KIND_SKIP_BCLR: begin strobe.isSkip   = 1'b1; strobe.condMet = !bitValue;   end
      KIND_SKIP_BSET: begin strobe.isSkip   = 1'b1; strobe.condMet = bitValue;    end
      default:        strobe = '0;
    endcase
  end

  // R11: a kind is a branch, a skip, or neither (reserved code)
  always_comb begin
    p_one_class_r11: assert (!(strobe.isBranch && strobe.isSkip))
      else $error("kind decoded as both branch and skip");
  end

endmodule

// File: rtl/bse_datapath.sv
module bse_datapath
  import bse_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalValid,
  input  logic [PC_W-1:0]  curPc,
  input  logic [OFF_W-1:0] relOffset,
  input  logic             nextIsLong,
  input  evalStrobe_t      strobe,
  output logic             resValid,
  output logic             resTaken,
  output logic [PC_W-1:0]  resNextPc,
  output logic [1:0]       resCycles
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] offsetExt;
  logic [PC_W-1:0] branchTarget;
  logic [PC_W-1:0] skipTarget;
  logic [PC_W-1:0] fallThrough;
  logic [PC_W-1:0] nextPcComb;
  logic [1:0]      cyclesComb;
  logic            takenComb;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offsetExt = {{EXT_W{relOffset[OFF_W-1]}}, relOffset};
    end else begin : g_trunc
      assign offsetExt = relOffset[PC_W-1:0];
    end
  endgenerate

  assign branchTarget = curPc + offsetExt + PC_W'(1);
  assign skipTarget   = curPc + (nextIsLong ? PC_W'(3) : PC_W'(2));
  assign fallThrough  = curPc + PC_W'(1);
  assign takenComb    = strobe.condMet && (strobe.isBranch || strobe.isSkip);

  always_comb begin
    nextPcComb = fallThrough;
    cyclesComb = 2'd1;
    if (takenComb && strobe.isBranch) begin
      nextPcComb = branchTarget;
      cyclesComb = 2'd2;
    end else if (takenComb && strobe.isSkip) begin
      nextPcComb = skipTarget;
      cyclesComb = nextIsLong ? 2'd3 : 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resTaken  <= 1'b0;
      resNextPc <= '0;
      resCycles <= 2'd0;
    end else begin
      resValid <= evalValid;
      if (evalValid) begin
        resTaken  <= takenComb;
        resNextPc <= nextPcComb;
        resCycles <= cyclesComb;
      end
    end
  end

  // R2: one result per request, one cycle later
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> resValid);
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> !resValid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> ($stable(resNextPc) && $stable(resCycles) && $stable(resTaken)));

  // R7: failed condition costs one cycle and steps by one
  p_not_taken_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resTaken) |-> (resCycles == 2'd1 && resNextPc == $past(curPc) + PC_W'(1)));

  // R6: taken branch lands on the relative target in two cycles
  p_branch_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken && $past(strobe.isBranch)) |->
      (resCycles == 2'd2 && resNextPc == $past(curPc) + $past(offsetExt) + PC_W'(1)));

  // R9: taken skip costs two or three cycles by instruction length
  p_skip_cost_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken && $past(strobe.isSkip)) |->
      (resCycles == ($past(nextIsLong) ? 2'd3 : 2'd2)));

endmodule

// File: rtl/branch_skip_eval.sv
module branch_skip_eval
  import bse_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 7,
  parameter int FLAG_W = 8,
  parameter int SEL_W  = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [PC_W-1:0]   curPc,
  input  logic [FLAG_W-1:0] statusFlags,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic [OFF_W-1:0]  relOffset,
  input  logic [3:0]        ctlKind,
  input  logic              bitValue,
  input  logic              regsEqual,
  input  logic              nextIsLong,
  output logic              resValid,
  output logic              resTaken,
  output logic [PC_W-1:0]   resNextPc,
  output logic [1:0]        resCycles
);

  evalStrobe_t strobe;

  bse_ctrl #(
    .FLAG_W(FLAG_W),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .statusFlags(statusFlags),
    .flagSel    (flagSel),
    .ctlKind    (ctlKind),
    .bitValue   (bitValue),
    .regsEqual  (regsEqual),
    .strobe     (strobe)
  );

  bse_datapath #(
    .PC_W (PC_W),
    .OFF_W(OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evalValid (evalValid),
    .curPc     (curPc),
    .relOffset (relOffset),
    .nextIsLong(nextIsLong),
    .strobe    (strobe),
    .resValid  (resValid),
    .resTaken  (resTaken),
    .resNextPc (resNextPc),
    .resCycles (resCycles)
  );

endmodule

// File: tb/branch_skip_eval_tb.sv
`timescale 1ns/1ps
module branch_skip_eval_tb;

  localparam int PC_W = 16;
  localparam int OFF_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evalValid = 1'b0;
  logic [PC_W-1:0] curPc = '0;
  logic [7:0] statusFlags = '0;
  logic [2:0] flagSel = '0;
  logic [OFF_W-1:0] relOffset = '0;
  logic [3:0] ctlKind = '0;
  logic bitValue = 1'b0;
  logic regsEqual = 1'b0;
  logic nextIsLong = 1'b0;
  logic resValid, resTaken;
  logic [PC_W-1:0] resNextPc;
  logic [1:0] resCycles;

  int checks = 0;
  int errors = 0;

  logic expValid = 1'b0;
  logic expTaken = 1'b0;
  logic [PC_W-1:0] expPc = '0;
  logic [1:0] expCyc = '0;

  always #2 clk = ~clk;

  branch_skip_eval u_dut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .curPc(curPc),
    .statusFlags(statusFlags), .flagSel(flagSel), .relOffset(relOffset),
    .ctlKind(ctlKind), .bitValue(bitValue), .regsEqual(regsEqual),
    .nextIsLong(nextIsLong), .resValid(resValid), .resTaken(resTaken),
    .resNextPc(resNextPc), .resCycles(resCycles)
  );

  task automatic compare(input string tag);
    checks++;
    if (resValid !== expValid || resTaken !== expTaken ||
        resNextPc !== expPc || resCycles !== expCyc) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0b pc=%h cyc=%0d, expected v=%0b t=%0b pc=%h cyc=%0d",
               tag, resValid, resTaken, resNextPc, resCycles,
               expValid, expTaken, expPc, expCyc);
    end
  endtask

  // behavioural model of one request
  task automatic model(input logic v, input logic [PC_W-1:0] pc, input logic [7:0] fl,
                       input logic [2:0] sel, input logic [OFF_W-1:0] off, input int kind,
                       input logic bv, input logic eq, input logic lng);
    int offVal;
    bit cond;
    bit branch;
    bit skip;
    if (!v) begin
      expValid = 1'b0;
      return;
    end
    offVal = off[OFF_W-1] ? int'(off) - (1 << OFF_W) : int'(off);
    branch = (kind <= 5);
    skip = (kind >= 6 && kind <= 8);
    case (kind)
      0: cond = fl[sel];
      1: cond = !fl[sel];
      2: cond = (fl[2] == fl[3]);
      3: cond = (fl[2] != fl[3]);
      4: cond = !fl[0];
      5: cond = fl[0];
      6: cond = eq;
      7: cond = !bv;
      8: cond = bv;
      default: cond = 0;
    endcase
    expValid = 1'b1;
    expTaken = cond;
    if (branch && cond) begin
      expPc = PC_W'(int'(pc) + offVal + 1);
      expCyc = 2;
    end else if (skip && cond) begin
      expPc = PC_W'(int'(pc) + (lng ? 3 : 2));
      expCyc = lng ? 2'd3 : 2'd2;
    end else begin
      expPc = PC_W'(int'(pc) + 1);
      expCyc = 1;
    end
  endtask

  task automatic apply(input logic v, input logic [PC_W-1:0] pc, input logic [7:0] fl,
                       input logic [2:0] sel, input logic [OFF_W-1:0] off, input int kind,
                       input logic bv, input logic eq, input logic lng, input string tag);
    evalValid = v; curPc = pc; statusFlags = fl; flagSel = sel; relOffset = off;
    ctlKind = 4'(kind); bitValue = bv; regsEqual = eq; nextIsLong = lng;
    model(v, pc, fl, sel, off, kind, bv, eq, lng);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rstN = 1'b1;

    // R3 selected-flag tests
    apply(1, 16'h0100, 8'h10, 3'd4, 7'h05, 0, 0, 0, 0, "R3 flag set taken");
    apply(1, 16'h0100, 8'h10, 3'd3, 7'h05, 0, 0, 0, 0, "R3 flag set not taken");
    apply(1, 16'h0200, 8'h10, 3'd3, 7'h7E, 1, 0, 0, 0, "R3 flag clear taken");
    apply(1, 16'h0200, 8'h80, 3'd7, 7'h7E, 1, 0, 0, 0, "R3 flag clear not taken");
    // R4 signed conditions
    apply(1, 16'h0300, 8'h04, 3'd0, 7'h10, 3, 0, 0, 0, "R4 less-than taken");
    apply(1, 16'h0300, 8'h04, 3'd0, 7'h10, 2, 0, 0, 0, "R4 greater-equal not taken");
    apply(1, 16'h0300, 8'h0C, 3'd0, 7'h10, 2, 0, 0, 0, "R4 greater-equal taken");
    apply(1, 16'h0300, 8'h0C, 3'd0, 7'h10, 3, 0, 0, 0, "R4 less-than not taken");
    // R5 carry aliases
    apply(1, 16'h0400, 8'h01, 3'd0, 7'h02, 5, 0, 0, 0, "R5 lower taken");
    apply(1, 16'h0400, 8'h01, 3'd0, 7'h02, 4, 0, 0, 0, "R5 same-or-higher not taken");
    apply(1, 16'h0400, 8'hFE, 3'd0, 7'h02, 4, 0, 0, 0, "R5 same-or-higher taken");
    // R6 offset extremes with wrap
    apply(1, 16'h0010, 8'h01, 3'd0, 7'h40, 5, 0, 0, 0, "R6 negative wrap");
    apply(1, 16'hFFFF, 8'h01, 3'd0, 7'h3F, 5, 0, 0, 0, "R6 positive wrap");
    // R8 / R9 skips
    apply(1, 16'h0500, 8'h00, 3'd0, 7'h00, 6, 0, 1, 1, "R9 equal skip long");
    apply(1, 16'h0500, 8'h00, 3'd0, 7'h00, 6, 0, 1, 0, "R8 equal skip short");
    apply(1, 16'h0500, 8'h00, 3'd0, 7'h00, 7, 0, 0, 0, "R8 bit-clear skip");
    apply(1, 16'hFFFE, 8'h00, 3'd0, 7'h00, 8, 1, 0, 1, "R9 bit-set skip long wrap");
    apply(1, 16'h0600, 8'h00, 3'd0, 7'h00, 8, 0, 1, 1, "R7 bit-set skip fails");
    apply(1, 16'hFFFF, 8'h00, 3'd0, 7'h00, 6, 0, 0, 1, "R7 equal skip fails wrap");
    // R10 length flag on a branch
    apply(1, 16'h0700, 8'h01, 3'd0, 7'h08, 5, 1, 1, 1, "R10 branch ignores length");
    apply(1, 16'h0700, 8'h00, 3'd0, 7'h08, 5, 1, 1, 1, "R10 untaken branch ignores length");
    // R11 reserved codes
    apply(1, 16'h0800, 8'hFF, 3'd7, 7'h20, 9, 1, 1, 1, "R11 code 9");
    apply(1, 16'h0800, 8'h00, 3'd0, 7'h20, 15, 0, 1, 1, "R11 code 15");
    // R2 idle cycles hold results
    apply(1, 16'h0900, 8'h01, 3'd0, 7'h03, 5, 0, 0, 0, "R2 before idle");
    apply(0, 16'h1234, 8'h00, 3'd0, 7'h00, 4, 0, 0, 0, "R2 idle hold");
    apply(0, 16'h4321, 8'hFF, 3'd0, 7'h00, 6, 0, 1, 1, "R2 second idle hold");

    for (int i = 0; i < 400; i++) begin
      apply(($urandom_range(0, 7) != 0), PC_W'($urandom), 8'($urandom),
            3'($urandom), OFF_W'($urandom), int'($urandom_range(0, 15)),
            1'($urandom), 1'($urandom), 1'($urandom), "random R6 R7 R9 mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule